// File: doc/BRIEF.md
# Trigger Busy Generator

This block produces the single BUSY level that a readout front end returns to the trigger system. Four conditions each hold BUSY high on their own: the trigger interface reports that it is not ready, the count of filled multi-event buffers has reached a programmable limit, a hold-off window is still open after an L0 trigger, or the trigger receiver is in the middle of a sequence. The block registers each cause separately in a 16-bit status word, next to the live buffer count and the limit, so that it is clear why the front end is busy.

The hold-off window is programmed in units of 10 µs. A prescaler divides the 25 ns clock by 400 to produce those units. Buffer occupancy is tracked from an accept pulse and a freed pulse. Because BUSY is the OR of all causes, the end of the window cannot release BUSY while the buffers are still full. A 32-bit counter accumulates the number of cycles spent busy and is presented as two 16-bit halves.

Top module: `trig_busy_gen`

## Requirements
- R1: Status bit 15 equals the inverse of `ifc_ready` as sampled on the previous clock edge.
- R2: Status bit 14 is 1 exactly when the buffer count held before the previous edge was greater than or equal to the limit held before that edge.
- R3: Status bit 13 is 1 while the L0 hold-off window is open. Status bit 12 equals `rx_seq_busy` as sampled on the previous edge.
- R4: Status bits 7:4 show the buffer count, bits 3:0 show the limit, and bits 11:8 read as 0. All are one cycle behind the internal state. A write on `lim_we` takes effect at the next edge.
- R5: When `l0_trig` is sampled high, the window loads the timeout setting. The window then stays open for exactly setting × 400 clock cycles. A new L0 reloads the window, and a setting of 0 opens no window. The setting resets to 10 and is changed with `tmo_we`.
- R6: `busy` equals the OR of status bits 15:12. It follows the causes one cycle after they occur. When the window closes while count ≥ limit, `busy` stays high.
- R7: The buffer count rises by 1 on `evt_accept` and falls by 1 on `buf_freed`. It saturates at 15 and at 0. When both pulses arrive in the same cycle, the count is unchanged.
- R8: The busy-time value {`busy_time_hi`,`busy_time_lo`} grows by 1 on every edge at which `busy` was high, and otherwise holds.
- R9: While `rst` is high, `busy`, `status` and the busy-time halves are 0. Reset also clears the count to 0, the limit to 0, closes the window, and sets the timeout to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 25 ns nominal |
| rst | input | 1 | Synchronous active-high reset |
| ifc_ready | input | 1 | Trigger interface ready level |
| rx_seq_busy | input | 1 | Trigger receiver is mid-sequence |
| l0_trig | input | 1 | L0 trigger pulse, one cycle |
| evt_accept | input | 1 | A multi-event buffer was filled |
| buf_freed | input | 1 | A multi-event buffer was released |
| lim_we | input | 1 | Write strobe for the buffer limit |
| lim_wdata | input | 4 | New buffer limit |
| tmo_we | input | 1 | Write strobe for the L0 timeout |
| tmo_wdata | input | 16 | New timeout in 10 µs units |
| busy | output | 1 | Registered BUSY level |
| status | output | 16 | Cause bits 15:12, zero 11:8, count 7:4, limit 3:0 |
| busy_time_hi | output | 16 | Busy-cycle counter bits 31:16 |
| busy_time_lo | output | 16 | Busy-cycle counter bits 15:0 |

## Verification
Faults in the buffer count or the limit appear one cycle later in status bits 7:0 and bit 14, and they disagree with a count the bench keeps from the accept and freed pulses. A prescaler or window counter that is off by even one cycle changes the length of the busy pulse that follows an L0. That length is measured exactly against setting × 400 cycles, so the error is visible by the end of the window. Any error in the cause logic affects the busy-time counter from that cycle onward and stays visible, because that value only accumulates.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  // Cause vector, MSB first so it packs directly into status[15:12].
  typedef struct packed {
    logic not_ready;
    logic buf_full;
    logic l0_window;
    logic rx_seq;
  } cause_t;

  localparam int STATUS_W = 16;
endpackage

// File: rtl/tbg_l0_timer.sv
module tbg_l0_timer #(
  parameter int TMO_W    = 16,
  parameter int PRESCALE = 400,
  parameter int TMO_RST  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [TMO_W-1:0] cfg_wdata,
  input  logic             l0,
  output logic             active
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [TMO_W-1:0] cfg_q;
  logic [TMO_W-1:0] units_q;
  logic [PW-1:0]    pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= TMO_W'(TMO_RST);
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      units_q <= '0;
      pre_q   <= '0;
    end else if (l0) begin
      units_q <= cfg_q;
      pre_q   <= '0;
    end else if (units_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_q   <= '0;
        units_q <= units_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign active = (units_q != '0);
endmodule

// File: rtl/tbg_buf_count.sv
module tbg_buf_count #(
  parameter int CNT_W   = 4,
  parameter int LIM_RST = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             full
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc && !dec && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec && !inc && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= CNT_W'(LIM_RST);
    end else if (lim_we) begin
      lim_q <= lim_wdata;
    end
  end

  assign count = cnt_q;
  assign limit = lim_q;
  assign full  = (cnt_q >= lim_q);
endmodule

// File: rtl/tbg_busy_time.sv
module tbg_busy_time #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] value
);
  logic [W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_q + 1'b1;
    end
  end

  assign value = acc_q;
endmodule

// File: rtl/trig_busy_gen.sv
module trig_busy_gen
  import tbg_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int TMO_W    = 16,
  parameter int PRESCALE = 400,
  parameter int TMO_RST  = 10,
  parameter int LIM_RST  = 0,
  parameter int BT_W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ifc_ready,
  input  logic               rx_seq_busy,
  input  logic               l0_trig,
  input  logic               evt_accept,
  input  logic               buf_freed,
  input  logic               lim_we,
  input  logic [CNT_W-1:0]   lim_wdata,
  input  logic               tmo_we,
  input  logic [TMO_W-1:0]   tmo_wdata,
  output logic               busy,
  output logic [15:0]        status,
  output logic [BT_W/2-1:0]  busy_time_hi,
  output logic [BT_W/2-1:0]  busy_time_lo
);
  localparam int HALF  = BT_W / 2;
  localparam int PAD_W = STATUS_W - 4 - 2 * CNT_W;

  logic             win_active;
  logic             buf_full;
  logic [CNT_W-1:0] buf_cnt;
  logic [CNT_W-1:0] buf_lim;
  logic [BT_W-1:0]  bt_value;
  cause_t           cause;
  logic             busy_q;
  logic [STATUS_W-1:0] status_q;

  tbg_l0_timer #(
    .TMO_W   (TMO_W),
    .PRESCALE(PRESCALE),
    .TMO_RST (TMO_RST)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (tmo_we),
    .cfg_wdata(tmo_wdata),
    .l0       (l0_trig),
    .active   (win_active)
  );

  tbg_buf_count #(
    .CNT_W  (CNT_W),
    .LIM_RST(LIM_RST)
  ) u_bufcnt (
    .clk      (clk),
    .rst      (rst),
    .inc      (evt_accept),
    .dec      (buf_freed),
    .lim_we   (lim_we),
    .lim_wdata(lim_wdata),
    .count    (buf_cnt),
    .limit    (buf_lim),
    .full     (buf_full)
  );

  always_comb begin
    cause.not_ready = ~ifc_ready;
    cause.buf_full  = buf_full;
    cause.l0_window = win_active;
    cause.rx_seq    = rx_seq_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      status_q <= '0;
    end else begin
      busy_q   <= |cause;
      status_q <= {cause, {PAD_W{1'b0}}, buf_cnt, buf_lim};
    end
  end

  tbg_busy_time #(.W(BT_W)) u_btime (
    .clk  (clk),
    .rst  (rst),
    .en   (busy_q),
    .value(bt_value)
  );

  assign busy         = busy_q;
  assign status       = status_q;
  assign busy_time_hi = bt_value[BT_W-1:HALF];
  assign busy_time_lo = bt_value[HALF-1:0];
endmodule

// File: rtl/trig_busy_gen_chk.sv
module trig_busy_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        ifc_ready,
  input logic        rx_seq_busy,
  input logic        busy,
  input logic [15:0] status,
  input logic [15:0] busy_time_hi,
  input logic [15:0] busy_time_lo
);
  logic pv;
  always_ff @(posedge clk) begin
    if (rst) pv <= 1'b0;
    else     pv <= 1'b1;
  end

  logic [31:0] bt;
  assign bt = {busy_time_hi, busy_time_lo};

  a_r1_not_ready: assert property (@(posedge clk) disable iff (rst)
    pv |-> (status[15] == !$past(ifc_ready)));

  a_r3_rx_seq: assert property (@(posedge clk) disable iff (rst)
    pv |-> (status[12] == $past(rx_seq_busy)));

  a_r6_busy_or: assert property (@(posedge clk) disable iff (rst)
    pv |-> (busy == |status[15:12]));

  a_r8_bt_step: assert property (@(posedge clk) disable iff (rst)
    pv |-> (bt == 32'($past(bt) + {31'd0, $past(busy)})));

  a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
    pv |-> (status[7:4] == $past(status[7:4]) ||
            status[7:4] == 4'($past(status[7:4]) + 4'd1) ||
            status[7:4] == 4'($past(status[7:4]) - 4'd1)));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (busy == 1'b0 && status == 16'h0 && bt == 32'h0));
endmodule

bind trig_busy_gen trig_busy_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .ifc_ready   (ifc_ready),
  .rx_seq_busy (rx_seq_busy),
  .busy        (busy),
  .status      (status),
  .busy_time_hi(busy_time_hi),
  .busy_time_lo(busy_time_lo)
);

// File: tb/sim_trig_busy_gen.sv
`timescale 1ns/1ps
module sim_trig_busy_gen;
  localparam int PRE = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy = 1'b1, rxb = 1'b0, l0 = 1'b0, acc = 1'b0, fr = 1'b0;
  logic        lwe = 1'b0, twe = 1'b0;
  logic [3:0]  lwd = '0;
  logic [15:0] twd = '0;
  logic        busy;
  logic [15:0] status, bt_hi, bt_lo;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trig_busy_gen u0 (
    .clk(clk), .rst(rst), .ifc_ready(rdy), .rx_seq_busy(rxb), .l0_trig(l0),
    .evt_accept(acc), .buf_freed(fr), .lim_we(lwe), .lim_wdata(lwd),
    .tmo_we(twe), .tmo_wdata(twd), .busy(busy), .status(status),
    .busy_time_hi(bt_hi), .busy_time_lo(bt_lo)
  );

  // Reference model built from the requirements
  logic        m_busy;
  logic [15:0] m_stat;
  logic [31:0] m_bt;
  logic [3:0]  m_cnt, m_lim;
  logic [15:0] m_tcfg, m_tmo;
  int          m_pre;

  function automatic logic [3:0] causes(logic r, logic [3:0] c, logic [3:0] l,
                                        logic [15:0] t, logic x);
    return {!r, c >= l, t != 0, x};
  endfunction

  always @(posedge clk) begin
    logic [3:0] c;
    if (rst) begin
      m_busy = 0; m_stat = 0; m_bt = 0; m_cnt = 0; m_lim = 0;
      m_tcfg = 16'd10; m_tmo = 0; m_pre = 0;
    end else begin
      c = causes(rdy, m_cnt, m_lim, m_tmo, rxb);
      m_bt   = m_bt + {31'd0, m_busy};
      m_busy = |c;
      m_stat = {c, 4'h0, m_cnt, m_lim};
      if (acc && !fr && m_cnt != 4'hF) m_cnt = m_cnt + 1;
      else if (fr && !acc && m_cnt != 0) m_cnt = m_cnt - 1;
      if (lwe) m_lim = lwd;
      if (l0) begin m_tmo = m_tcfg; m_pre = 0; end
      else if (m_tmo != 0) begin
        if (m_pre == PRE - 1) begin m_pre = 0; m_tmo = m_tmo - 1; end
        else m_pre = m_pre + 1;
      end
      if (twe) m_tcfg = twd;
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(status[15], m_stat[15], "R1 not-ready bit");
      chk(status[14], m_stat[14], "R2 buffer-full bit");
      chk(status[13:12], m_stat[13:12], "R3 window/rx bits");
      chk(status[11:0], m_stat[11:0], "R4 count/limit field");
      chk(busy, m_busy, "R6 busy level");
      chk({bt_hi, bt_lo}, m_bt, "R8 busy time");
    end
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_acc(int n);
    repeat (n) begin acc = 1; step(1); acc = 0; end
  endtask
  task automatic pulse_fr(int n);
    repeat (n) begin fr = 1; step(1); fr = 0; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    step(3);
    // R9: reset state
    chk(busy, 0, "R9 reset busy");
    chk(status, 0, "R9 reset status");
    chk({bt_hi, bt_lo}, 0, "R9 reset busy time");
    rst = 0;
    step(2);
    // R9/R2: limit 0 resets, so count 0 >= 0 holds busy
    chk(status[14], 1, "R9 limit resets to 0, R2 full");
    lwe = 1; lwd = 4'd15; step(1); lwe = 0;
    step(3);
    chk(busy, 0, "R2 not full with limit 15");
    chk(status[3:0], 15, "R4 limit field");
    // R5: default window 10 units = 4000 cycles
    l0 = 1; step(1); l0 = 0;
    n = 0;
    repeat (4100) begin step(1); if (busy) n++; end
    chk(n, 10 * PRE, "R5 default window length");
    // R5: window of 2 units after reprogramming
    twe = 1; twd = 16'd2; step(1); twe = 0;
    l0 = 1; step(1); l0 = 0;
    n = 0;
    repeat (900) begin step(1); if (busy) n++; end
    chk(n, 2 * PRE, "R5 programmed window length");
    // R5: setting 0 opens no window
    twe = 1; twd = 16'd0; step(1); twe = 0;
    l0 = 1; step(1); l0 = 0;
    step(3);
    chk(busy, 0, "R5 zero setting no window");
    // R6: window expiry with full buffers keeps busy
    lwe = 1; lwd = 4'd2; step(1); lwe = 0;
    pulse_acc(2);
    twe = 1; twd = 16'd1; step(1); twe = 0;
    l0 = 1; step(1); l0 = 0;
    step(PRE + 50);
    chk(status[13], 0, "R6 window closed");
    chk(busy, 1, "R6 busy held while full");
    pulse_fr(1);
    step(2);
    chk(busy, 0, "R6 busy drops once not full");
    // R7: saturation and simultaneous pulses
    pulse_acc(20);
    step(2);
    chk(status[7:4], 15, "R7 saturate high");
    pulse_fr(20);
    step(2);
    chk(status[7:4], 0, "R7 saturate low");
    pulse_acc(3);
    acc = 1; fr = 1; step(1); acc = 0; fr = 0;
    step(2);
    chk(status[7:4], 3, "R7 simultaneous unchanged");
    // R1/R3: direct cause inputs
    rdy = 0; step(2);
    chk(status[15], 1, "R1 not ready");
    rdy = 1; rxb = 1; step(2);
    chk(status[12], 1, "R3 rx busy");
    rxb = 0;
    // Random phase
    repeat (20000) begin
      rdy = ($urandom % 8) != 0;
      rxb = ($urandom % 6) == 0;
      l0  = ($urandom % 300) == 0;
      acc = ($urandom % 5) == 0;
      fr  = ($urandom % 5) == 0;
      lwe = ($urandom % 200) == 0;
      lwd = 4'($urandom);
      twe = ($urandom % 400) == 0;
      twd = 16'($urandom % 3);
      step(1);
    end
    {rdy, rxb, l0, acc, fr, lwe, twe} = 7'b1000000;
    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule